// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire bus target that behaves like a small serial EEPROM holding 256 bytes. It runs on a fast system clock. It treats the bus clock and data lines as ordinary inputs, samples them through a synchronizer, and reconstructs the bus events from the sampled edges. It never drives a line high. It only asserts an output enable that, outside the block, pulls the data line low through an open-drain pad.

A controller writes a byte in one frame: the target address with the direction bit clear, a word address, then the data byte. To read a byte back, the controller first writes the word address in a write frame without data. It then issues a repeated START and the target address with the direction bit set. The target answers with the byte at the word pointer. An internal word pointer advances after every byte stored or sent, and it wraps from the top address to zero. This makes two more accesses possible: a read that uses the current address, and bursts of several bytes.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, and for as long as the bus stays idle (both lines high), `sda_oe` is 0.
- R2: The first byte after a START is seven address bits, MSB first, followed by a direction bit (0 = write, 1 = read). The target pulls the data line low during the ninth clock only when the seven bits equal `DEV_ADDR` (default 0x50, so the bytes are 0xA0 and 0xA1). For any other address it stays off the bus until the next START.
- R3: In a write frame, the byte after the address byte loads the word pointer, and every following byte is stored at the word pointer. Each of these bytes is acknowledged by a low data line in the ninth clock.
- R4: In a read frame, the target sends the byte at the word pointer MSB first. It changes the line only while the clock is low, so the controller samples each bit while the clock is high.
- R5: The word pointer advances by one after every byte stored or sent, and it wraps from 255 to 0. A read frame that has no word-address phase before it returns the byte at the current pointer. In a read burst, each low (acknowledge) bit from the controller in the ninth clock starts the next byte.
- R6: `sda_oe` changes only while the bus clock is low. It is released after each acknowledge bit and after the eighth bit of each byte the target sends.
- R7: If the controller answers a sent byte with a high (no-acknowledge) bit, the target stays off the bus until the next START.
- R8: A START or STOP seen at any point aborts the current byte. A START restarts address reception. A STOP returns the target to idle. An incomplete byte is never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain); 0 releases it |

## Verification
Two things can happen on the same falling edge of the bus clock. The storing of a received data byte and the advance of the word pointer come together. So do the fetch of a byte to send and the advance of the pointer past it. These events are provoked at the top address, where the advance must wrap to zero. A write burst that crosses 255 is read back with a random read and with a read burst that crosses the same boundary. A write followed at once by a read that uses the current address shows whether the pointer landed one past the stored byte. Each returned byte is judged against a bench model of the 256 bytes and its pointer.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  typedef enum logic [3:0] {
    ENG_IDLE,
    ENG_ADDR,
    ENG_ADDR_ACK,
    ENG_WORD,
    ENG_WORD_ACK,
    ENG_WDATA,
    ENG_WDATA_ACK,
    ENG_RDATA,
    ENG_RACK
  } eng_state_t;

  localparam int LINE_COUNT = 2;
  localparam int LINE_SCL   = 0;
  localparam int LINE_SDA   = 1;

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  import i2c_ee_pkg::*;

  logic [LINE_COUNT-1:0] raw_in;
  logic [LINE_COUNT-1:0] synced;
  logic [LINE_COUNT-1:0] prev;

  assign raw_in[LINE_SCL] = scl_raw;
  assign raw_in[LINE_SDA] = sda_raw;

  for (genvar g = 0; g < LINE_COUNT; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain   <= '1;
        prev[g] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw_in[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign scl_s = synced[LINE_SCL];
  assign sda_s = synced[LINE_SDA];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_rise  <= synced[LINE_SCL] & ~prev[LINE_SCL];
      scl_fall  <= ~synced[LINE_SCL] & prev[LINE_SCL];
      start_det <= synced[LINE_SCL] & prev[LINE_SCL] & prev[LINE_SDA] & ~synced[LINE_SDA];
      stop_det  <= synced[LINE_SCL] & prev[LINE_SCL] & ~prev[LINE_SDA] & synced[LINE_SDA];
    end
  end

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/i2c_ee_engine.sv
module i2c_ee_engine #(
  parameter int       AW       = 8,
  parameter int       DW       = 8,
  parameter bit [6:0] DEV_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] word_ptr,
  output logic          eng_idle,
  output logic          ptr_inc,
  output logic          ptr_load
);
  import i2c_ee_pkg::*;

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  eng_state_t    state;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_sh;
  logic [DW-1:0] tx_sh;
  logic          ctrl_ack;
  logic          byte_done;

  assign byte_done = scl_fall && (bit_cnt == FULL);
  assign eng_idle  = (state == ENG_IDLE);

  always_comb begin
    ptr_inc  = 1'b0;
    ptr_load = 1'b0;
    if (!start_det && !stop_det) begin
      case (state)
        ENG_ADDR_ACK: ptr_inc  = scl_fall && rx_sh[0];
        ENG_WORD:     ptr_load = byte_done;
        ENG_WDATA:    ptr_inc  = byte_done;
        ENG_RACK:     ptr_inc  = scl_fall && ctrl_ack;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word_ptr <= '0;
    else if (ptr_load) word_ptr <= rx_sh[AW-1:0];
    else if (ptr_inc) word_ptr <= word_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      sda_oe    <= 1'b0;
      ctrl_ack  <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        state   <= ENG_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state   <= ENG_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          ENG_ADDR, ENG_WORD, ENG_WDATA: begin
            if (scl_rise && bit_cnt != FULL) begin
              rx_sh   <= {rx_sh[DW-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              if (state == ENG_ADDR) begin
                if (rx_sh[DW-1:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  state  <= ENG_ADDR_ACK;
                end else begin
                  state <= ENG_IDLE;
                end
              end else if (state == ENG_WORD) begin
                sda_oe <= 1'b1;
                state  <= ENG_WORD_ACK;
              end else begin
                mem_we    <= 1'b1;
                mem_waddr <= word_ptr;
                mem_wdata <= rx_sh;
                sda_oe    <= 1'b1;
                state     <= ENG_WDATA_ACK;
              end
            end
          end
          ENG_ADDR_ACK: begin
            if (scl_fall) begin
              if (rx_sh[0]) begin
                tx_sh   <= rd_data;
                sda_oe  <= ~rd_data[DW-1];
                bit_cnt <= CW'(1);
                state   <= ENG_RDATA;
              end else begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                state   <= ENG_WORD;
              end
            end
          end
          ENG_WORD_ACK, ENG_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ENG_WDATA;
            end
          end
          ENG_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt == FULL) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                state   <= ENG_RACK;
              end else begin
                sda_oe  <= ~tx_sh[DW-2];
                tx_sh   <= {tx_sh[DW-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ENG_RACK: begin
            if (scl_rise) begin
              ctrl_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (ctrl_ack) begin
                tx_sh   <= rd_data;
                sda_oe  <= ~rd_data[DW-1];
                bit_cnt <= CW'(1);
                state   <= ENG_RDATA;
              end else begin
                state <= ENG_IDLE;
              end
            end
          end
          default: state <= ENG_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int       AW          = 8,
  parameter int       DW          = 8,
  parameter int       SYNC_STAGES = 2,
  parameter bit [6:0] DEV_ADDR    = 7'h50
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_seen;
  logic          stop_seen;
  logic [DW-1:0] rd_data;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic [AW-1:0] word_ptr;
  logic          eng_idle;
  logic          ptr_inc;
  logic          ptr_load;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_seen), .stop_det(stop_seen)
  );

  i2c_ee_engine #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_seen), .stop_det(stop_seen), .rd_data(rd_data),
    .sda_oe(sda_oe), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .word_ptr(word_ptr), .eng_idle(eng_idle), .ptr_inc(ptr_inc), .ptr_load(ptr_load)
  );

  i2c_ee_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(word_ptr), .rdata(rd_data)
  );

endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          eng_idle,
  input logic          start_seen,
  input logic [AW-1:0] word_ptr,
  input logic          ptr_inc,
  input logic          ptr_load
);

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> !sda_oe);

  assert_oe_moves_low_scl_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (rst)
    eng_idle |-> !sda_oe);

  assert_start_releases_R8: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> !sda_oe);

  assert_ptr_step_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && !ptr_load) |=> (word_ptr == AW'($past(word_ptr) + 1'b1)));

endmodule

bind i2c_eeprom_target i2c_ee_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .eng_idle(eng_idle),
  .start_seen(start_seen), .word_ptr(word_ptr), .ptr_inc(ptr_inc), .ptr_load(ptr_load)
);

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe;
  logic sda_line;

  int checks = 0;
  int fails = 0;
  int viol = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] addrs [16];

  always #2 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;

  i2c_eeprom_target dut (.clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe));

  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (!rst && sda_oe !== oe_prev && scl) viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] exp_byte(input logic [7:0] a);
    return model[a];
  endfunction

  function automatic logic [7:0] next_addr(input logic [7:0] a);
    return a + 8'd1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b; tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_drv = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = !a;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!give_ack);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    bit k0, k1, k2;
    bus_start();
    put_byte(8'hA0, k0);
    put_byte(a, k1);
    put_byte(d, k2);
    bus_stop();
    check(k0, "R2 address ack on write", k0, 1);
    check(k1 && k2, "R3 word/data ack", {k1, k2}, 3);
    model[a] = d;
  endtask

  task automatic do_rread(input logic [7:0] a, output logic [7:0] d);
    bit k0, k1, k2;
    bus_start();
    put_byte(8'hA0, k0);
    put_byte(a, k1);
    bus_start();
    put_byte(8'hA1, k2);
    get_byte(d, 1'b0);
    bus_stop();
    check(k0 && k1 && k2, "R2 acks in random read", {k0, k1, k2}, 7);
  endtask

  initial begin
    int unused_seed;
    logic [7:0] d, d2, d3;
    bit k0, k1, k2, k3;
    unused_seed = $urandom(32'h5EED_0042);
    tick(10);
    rst = 1'b0;
    tick(40);
    check(sda_oe == 1'b0, "R1 released after reset on idle bus", sda_oe, 0);

    // R3/R4 random write then read back
    for (int i = 0; i < 16; i++) begin
      addrs[i] = 8'($urandom % 256);
      do_write(addrs[i], 8'($urandom));
    end
    for (int i = 0; i < 16; i++) begin
      do_rread(addrs[i], d);
      check(d == exp_byte(addrs[i]), "R4 random read data", d, exp_byte(addrs[i]));
    end

    // R2 wrong address: no ack, bus stays released
    bus_start();
    put_byte(8'hA2, k0);
    get_byte(d, 1'b0);
    bus_stop();
    check(!k0, "R2 foreign address not acked", k0, 0);
    check(d == 8'hFF, "R2 target silent after foreign address", d, 8'hFF);

    // R5 current address read after writes
    do_write(8'h80, 8'h11);
    do_write(8'h81, 8'h22);
    do_write(8'h80, 8'h33);
    bus_start();
    put_byte(8'hA1, k0);
    get_byte(d, 1'b0);
    bus_stop();
    check(k0 && d == exp_byte(next_addr(8'h80)), "R5 current address read", d, exp_byte(8'h81));

    // R5 burst write across 255 -> 0
    do_write(8'hFE, 8'h9C);
    bus_start();
    put_byte(8'hA0, k0);
    put_byte(8'hFF, k1);
    put_byte(8'hC3, k2);
    put_byte(8'h3C, k3);
    bus_stop();
    model[8'hFF] = 8'hC3;
    model[next_addr(8'hFF)] = 8'h3C;
    check(k0 && k1 && k2 && k3, "R3 burst write acks", {k0, k1, k2, k3}, 15);
    do_rread(8'h00, d);
    check(d == exp_byte(8'h00), "R5 write wrapped to address 0", d, exp_byte(8'h00));

    // R5 burst read across 255 -> 0
    bus_start();
    put_byte(8'hA0, k0);
    put_byte(8'hFE, k1);
    bus_start();
    put_byte(8'hA1, k2);
    get_byte(d, 1'b1);
    get_byte(d2, 1'b1);
    get_byte(d3, 1'b0);
    // R7 after no-ack, target stays silent
    get_byte(d, 1'b0);
    bus_stop();
    check(d2 == exp_byte(8'hFF), "R5 burst read byte at 255", d2, exp_byte(8'hFF));
    check(d3 == exp_byte(8'h00), "R5 burst read wrapped to 0", d3, exp_byte(8'h00));
    check(d == 8'hFF, "R7 silent after controller no-ack", d, 8'hFF);

    // R8 START inside a data byte: nothing stored
    do_write(8'h40, 8'h5A);
    bus_start();
    put_byte(8'hA0, k0);
    put_byte(8'h40, k1);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_start();
    put_byte(8'hA0, k2);
    put_byte(8'h40, k3);
    bus_start();
    put_byte(8'hA1, k0);
    get_byte(d, 1'b0);
    bus_stop();
    check(k2 && k3 && d == exp_byte(8'h40), "R8 repeated START aborts partial byte", d, exp_byte(8'h40));

    // R8 STOP inside the address byte, then normal traffic
    bus_start();
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_stop();
    tick(20);
    check(sda_oe == 1'b0, "R8 STOP returns to idle", sda_oe, 0);
    do_write(8'h41, 8'hE7);
    do_rread(8'h41, d);
    check(d == exp_byte(8'h41), "R8 traffic after aborted frame", d, exp_byte(8'h41));

    check(viol == 0, "R6 oe changes only while clock low", viol, 0);
    tick(20);
    check(sda_oe == 1'b0, "R1 released on idle bus at end", sda_oe, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule